// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control around one 12-bit voltage converter. A host reaches it through a small byte-wide register port. It holds a channel selection and a self-clearing start bit, and it counts out the fixed conversion time from the clock rate. When a conversion ends it captures the converter's result bus into a right-aligned two-byte result, marks that result valid and raises a completion flag. The flag drives an interrupt output when interrupts are enabled.

A channel written while a conversion runs is held back until that conversion ends. A pulse on the prescaler-change input aborts the conversion in progress. Two of the channels form a pair. Picking either one of them drives the pin-role control that turns the other pin into signal ground.

Top module: `adc_seq`

## Requirements
- R1: Writing CTRL (address 0) with bit 0 set while idle starts a conversion on the selected channel. CTRL read bit 0 (busy) is 1 from the next cycle on.
- R2: A conversion lasts N = floor(floor(CLK_HZ/1000)*CONV_US/1000) cycles. Busy clears and the flag (CTRL read bit 2) sets at the N-th rising edge after the start edge.
- R3: The valid bit (CTRL read bit 3) is 0 while a conversion runs and 1 after it completes. The result bytes stay unchanged until the next completion, whatever the result bus does in between.
- R4: The result bus is sampled at the completing edge. Address 2 reads result bits 7:0. Address 3 reads 0000 in bits 7:4 and result bits 11:8 in bits 3:0.
- R5: A prescaler-change pulse during a conversion clears busy at that edge. It leaves the flag unset and valid at 0, and it leaves the result bytes unchanged.
- R6: A channel write (address 1) reads back at once. During a conversion `adc_chan` keeps the old channel up to and including the completing edge and takes the new value one cycle later. While idle, `adc_chan` follows one cycle after the write.
- R7: Active channel 0 drives `pin1_sgnd` high, active channel 1 drives `pin0_sgnd` high, and any other channel drives neither.
- R8: Writing CTRL with bit 2 set clears the flag, and writing bit 2 as 0 leaves it alone. A completion in the same cycle as a clear leaves the flag set.
- R9: Every CTRL write loads the interrupt enable from bit 1 (read back in bit 1). `irq` is high exactly when the flag and the enable are both set.
- R10: A start write during a conversion has no effect, and the conversion still ends N cycles after its own start.
- R11: After reset CTRL, both result bytes and the channel read 0, `pin1_sgnd` is 1 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |
| presc_chg | input | 1 | Pulse: the clock prescaler was changed |
| adc_result | input | 12 | Result bus from the analog converter |
| adc_chan | output | CHW | Channel in use by the converter |
| pin0_sgnd | output | 1 | Switch pin 0 to signal ground |
| pin1_sgnd | output | 1 | Switch pin 1 to signal ground |
| irq | output | 1 | Completion interrupt |

## Verification
Every register updates on the edge that samples the write, and reads are combinational. The bench therefore reads CTRL, the result bytes and the channel in the low phase right after the edge in question. Completion is due at the N-th edge after the start edge. The bench checks busy one edge before that and the flag, valid bit and result one edge after the start of that window. `adc_chan` is due one edge after a write or a completion, and the checks step exactly that one extra edge before sampling. The abort and the clear-versus-completion race are each lined up on a counted edge.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int CLK_HZ  = 4_000_000,
  parameter int CONV_US = 519,
  parameter int CHW     = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [1:0]     reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic           presc_chg,
  input  logic [11:0]    adc_result,
  output logic [CHW-1:0] adc_chan,
  output logic           pin0_sgnd,
  output logic           pin1_sgnd,
  output logic           irq
);

  localparam int CYC_RAW = (CLK_HZ / 1000) * CONV_US / 1000;
  localparam int N       = (CYC_RAW < 1) ? 1 : CYC_RAW;
  localparam int CW      = $clog2(N + 1);

  logic           busy, ie, flag, valid;
  logic [CW-1:0]  cnt;
  logic [CHW-1:0] chan_req, chan_act;
  logic [11:0]    res_q;

  wire wr_ctrl   = reg_we && (reg_addr == 2'd0);
  wire wr_chan   = reg_we && (reg_addr == 2'd1);
  wire start_req = wr_ctrl && reg_wdata[0] && !busy;
  wire abort     = busy && presc_chg;
  wire done      = busy && !presc_chg && (cnt == CW'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      valid <= 1'b0;
      res_q <= '0;
    end else if (start_req) begin
      busy  <= 1'b1;
      cnt   <= '0;
      valid <= 1'b0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (done) begin
      busy  <= 1'b0;
      cnt   <= '0;
      valid <= 1'b1;
      res_q <= adc_result;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      ie       <= 1'b0;
      chan_req <= '0;
      chan_act <= '0;
    end else begin
      if (done)                         flag <= 1'b1;
      else if (wr_ctrl && reg_wdata[2]) flag <= 1'b0;
      if (wr_ctrl) ie <= reg_wdata[1];
      if (wr_chan) chan_req <= reg_wdata[CHW-1:0];
      if (!busy)   chan_act <= chan_req;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {4'b0000, valid, flag, ie, busy};
      2'd1:    reg_rdata = 8'(chan_req);
      2'd2:    reg_rdata = res_q[7:0];
      default: reg_rdata = {4'b0000, res_q[11:8]};
    endcase
  end

  assign adc_chan  = chan_act;
  assign pin1_sgnd = (chan_act == CHW'(0));
  assign pin0_sgnd = (chan_act == CHW'(1));
  assign irq       = flag && ie;

  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(presc_chg) |-> flag && valid); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < CW'(N)); // R2
  AST_INVALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !valid); // R3
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && $past(presc_chg) |-> !busy && !valid); // R5
  AST_CHAN_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(adc_chan) |-> !$past(busy)); // R6
  AST_HIGH_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> reg_rdata[7:4] == 4'h0); // R4

endmodule

// File: tb/adc_seq_bench.sv
module adc_seq_bench;
  localparam int CLK_HZ = 20_000;
  localparam int CONV_US = 519;
  localparam int N = (CLK_HZ / 1000) * CONV_US / 1000;

  logic clk = 0, rst_n = 0, reg_we = 0, presc_chg = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [11:0] adc_result = 0;
  logic [1:0] adc_chan;
  logic pin0_sgnd, pin1_sgnd, irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  adc_seq #(.CLK_HZ(CLK_HZ), .CONV_US(CONV_US), .CHW(2)) u_adc_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .presc_chg(presc_chg),
    .adc_result(adc_result), .adc_chan(adc_chan), .pin0_sgnd(pin0_sgnd),
    .pin1_sgnd(pin1_sgnd), .irq(irq));

  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(0, d); chk("R11 ctrl", d, 8'h00);
    rd(1, d); chk("R11 chan", d, 8'h00);
    rd(2, d); chk("R11 lo", d, 8'h00);
    rd(3, d); chk("R11 hi", d, 8'h00);
    chk("R11 pin1_sgnd", pin1_sgnd, 1'b1);
    chk("R11 irq", irq, 1'b0);
  endtask

  task automatic t_basic;
    logic [7:0] d;
    adc_result = 12'hA5C;
    wr(0, 8'h01);
    rd(0, d); chk("R1 busy after start", d, 8'h01);
    step(N - 1);
    rd(0, d); chk("R2 busy before end", d, 8'h01);
    step(1);
    rd(0, d); chk("R2 R3 done flag valid", d, 8'h0C);
    rd(2, d); chk("R4 low byte", d, 8'h5C);
    rd(3, d); chk("R4 high byte", d, 8'h0A);
    adc_result = 12'h123;
    step(5);
    rd(2, d); chk("R3 low held", d, 8'h5C);
    rd(3, d); chk("R3 high held", d, 8'h0A);
    wr(0, 8'h04);
    rd(0, d); chk("R8 flag cleared", d, 8'h08);
  endtask

  task automatic t_format(logic [11:0] v);
    logic [7:0] d;
    adc_result = ~v;
    wr(0, 8'h01);
    rd(0, d); chk("R3 invalid during conv", d[3], 1'b0);
    step(N - 1);
    adc_result = v;
    step(1);
    rd(2, d); chk("R4 low sampled at end", d, v[7:0]);
    rd(3, d); chk("R4 high sampled at end", d, {4'h0, v[11:8]});
    wr(0, 8'h04);
  endtask

  task automatic t_abort;
    logic [7:0] d;
    logic [7:0] lo, hi;
    rd(2, lo); rd(3, hi);
    adc_result = 12'h777;
    wr(0, 8'h01);
    step(3);
    presc_chg = 1;
    @(posedge clk); @(negedge clk);
    presc_chg = 0;
    rd(0, d); chk("R5 aborted ctrl", d, 8'h00);
    step(N + 2);
    rd(0, d); chk("R5 no late flag", d, 8'h00);
    rd(2, d); chk("R5 low unchanged", d, lo);
    rd(3, d); chk("R5 high unchanged", d, hi);
  endtask

  task automatic t_restart;
    logic [7:0] d;
    wr(0, 8'h01);
    step(4);
    wr(0, 8'h01);
    step(3);
    rd(0, d); chk("R10 still busy", d[0], 1'b1);
    step(1);
    rd(0, d); chk("R10 ends on first start", d, 8'h0C);
    wr(0, 8'h04);
  endtask

  task automatic t_chan;
    logic [7:0] d;
    wr(1, 8'h00); step(1);
    chk("R7 ch0 chan", adc_chan, 2'd0);
    chk("R7 ch0 pin1", pin1_sgnd, 1'b1);
    chk("R7 ch0 pin0", pin0_sgnd, 1'b0);
    wr(1, 8'h01); step(1);
    chk("R7 ch1 pin0", pin0_sgnd, 1'b1);
    chk("R7 ch1 pin1", pin1_sgnd, 1'b0);
    wr(1, 8'h02); step(1);
    chk("R7 ch2 none", {pin0_sgnd, pin1_sgnd}, 2'b00);
    rd(1, d); chk("R6 chan readback", d, 8'h02);
    wr(1, 8'h01); step(1);
    wr(0, 8'h01);
    step(2);
    wr(1, 8'h03);
    rd(1, d); chk("R6 readback immediate", d, 8'h03);
    chk("R6 old chan kept", adc_chan, 2'd1);
    chk("R7 pin0 kept", pin0_sgnd, 1'b1);
    step(5);
    chk("R6 old chan near end", adc_chan, 2'd1);
    step(1);
    chk("R6 old chan at end", adc_chan, 2'd1);
    step(1);
    chk("R6 new chan after end", adc_chan, 2'd3);
    chk("R7 pin0 released", pin0_sgnd, 1'b0);
    wr(0, 8'h04);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    wr(0, 8'h02);
    chk("R9 irq no flag", irq, 1'b0);
    wr(0, 8'h03);
    step(N);
    chk("R9 irq raised", irq, 1'b1);
    rd(0, d); chk("R9 ctrl", d, 8'h0E);
    wr(0, 8'h02);
    chk("R8 write0 keeps flag", irq, 1'b1);
    wr(0, 8'h06);
    chk("R8 clear drops irq", irq, 1'b0);
    wr(0, 8'h03);
    step(N - 2);
    wr(0, 8'h06);
    rd(0, d); chk("R8 set beats clear", d[2], 1'b1);
    wr(0, 8'h00);
    chk("R9 irq masked", irq, 1'b0);
    rd(0, d); chk("R9 flag still set", d[2], 1'b1);
    wr(0, 8'h04);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    t_reset();
    t_basic();
    t_format(12'h3F1);
    t_format(12'hFFF);
    t_abort();
    t_restart();
    t_chan();
    t_irq();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule